// File: doc/BRIEF.md
# Paired Store Release Buffer

This block sits between the write-through L1 caches of two redundant cores and a shared L2 write port. Each core owns a first-in first-out store queue; every store that leaves its L1 is queued as a separate entry (never merged) together with the address of the instruction that produced it. The two queues are matched by program-order position: the k-th store of one core pairs with the k-th store of the other.

In paired mode a store leaves for L2 only when both queues hold it. A single copy, the one from core A, is sent, and the matching entry is removed from both queues in the same cycle. The oldest pairs go first, so every store up to the newest one both cores have completed eventually reaches L2. A full queue raises its core's stall until the other core catches up and entries drain. In decoupled mode each queue drains its own stores, and the two take turns when both are waiting. A recovery request freezes draining once the outstanding L2 write finishes. The faulty core's queue is then overwritten with the healthy core's queue.

Top module: `dual_store_buffer`

## Requirements
- R1: After reset both queues are empty, `l2_valid_o`, both stall outputs and `recover_done_o` are low.
- R2: A store is queued when its core's valid input is high, its stall is low and `recover_i` is low. Stores to the same address are never merged and each reaches L2 as its own write.
- R3: In paired mode (`decouple_i` = 0) the k-th store is sent only when both queues hold their k-th store. It is sent once, carrying core A's tag, address, data and mask, and stores leave in program order.
- R4: A queue holding DEPTH (default 10) entries raises its stall output. A push into a full queue is dropped. The stall clears once entries drain.
- R5: The L2 port allows one outstanding write: while `l2_valid_o` is high and `l2_ready_i` is low, all L2 outputs hold their values and no further entry leaves a queue.
- R6: While `recover_i` is high no new L2 write starts, an already offered write still completes, and pushes from both cores are dropped.
- R7: Under `recover_i`, once no write is outstanding, the faulty core's queue (`faulty_core_i` 0 = A, 1 = B) becomes an exact copy of the other queue. `recover_done_o` is high from the next cycle until `recover_i` falls.
- R8: In decoupled mode (`decouple_i` = 1) each queue drains on its own even when the other is empty. `l2_src_o` names the source (0 = A, 1 = B), and when both queues wait, A is served first after reset and the two then alternate.
- R9: In paired mode `l2_src_o` is 0 for every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| decouple_i | input | 1 | 1 = each queue drains on its own |
| recover_i | input | 1 | Recovery freeze and copy request |
| faulty_core_i | input | 1 | Queue to overwrite: 0 = A, 1 = B |
| a_valid_i | input | 1 | Core A store valid |
| a_tag_i | input | 32 | Core A instruction-address tag |
| a_addr_i | input | 32 | Core A store address |
| a_data_i | input | 32 | Core A store data |
| a_mask_i | input | 4 | Core A byte mask |
| a_stall_o | output | 1 | Core A queue full |
| b_valid_i | input | 1 | Core B store valid |
| b_tag_i | input | 32 | Core B instruction-address tag |
| b_addr_i | input | 32 | Core B store address |
| b_data_i | input | 32 | Core B store data |
| b_mask_i | input | 4 | Core B byte mask |
| b_stall_o | output | 1 | Core B queue full |
| l2_valid_o | output | 1 | L2 write offered |
| l2_ready_i | input | 1 | L2 accepts the write |
| l2_tag_o | output | 32 | Tag of offered write |
| l2_addr_o | output | 32 | Address of offered write |
| l2_data_o | output | 32 | Data of offered write |
| l2_mask_o | output | 4 | Byte mask of offered write |
| l2_src_o | output | 1 | Source queue of offered write |
| recover_done_o | output | 1 | Copy-over complete |

## Verification
The case where two functions meet in one cycle is a recovery request that arrives while an L2 write is held by a low `l2_ready_i`, with both queues still holding paired entries behind it. The bench raises `recover_i` during that stall and then releases ready for one cycle. It requires that exactly the held write is logged, that no later write starts while frozen, and that `recover_done_o` rises only after the acceptance. After the freeze lifts, the next write must carry the healthy queue's copied tag rather than the faulty queue's old entry. A second overlap occurs in the full-queue case, where a push and a paired drain hit the same queue in the same cycle. The bench judges it by the exact count and order of the writes that reach L2.

// File: rtl/cwb_pkg.sv
`timescale 1ns/1ps
package cwb_pkg;
  localparam int unsigned TAG_W  = 32;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned MASK_W = DATA_W / 8;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [MASK_W-1:0] mask;
  } cwb_entry_t;
endpackage

// File: rtl/cwb_fifo.sv
`timescale 1ns/1ps
module cwb_fifo
  import cwb_pkg::*;
#(
  parameter int unsigned DEPTH = 10,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   push_i,
  input  cwb_entry_t             push_data_i,
  input  logic                   pop_i,
  input  logic                   load_i,
  input  cwb_entry_t [DEPTH-1:0] load_mem_i,
  input  logic [PW-1:0]          load_rd_i,
  input  logic [PW-1:0]          load_wr_i,
  input  logic [CW-1:0]          load_cnt_i,
  output cwb_entry_t [DEPTH-1:0] mem_o,
  output logic [PW-1:0]          rd_o,
  output logic [PW-1:0]          wr_o,
  output logic [CW-1:0]          cnt_o,
  output cwb_entry_t             head_o,
  output logic                   full_o
);
  cwb_entry_t [DEPTH-1:0] mem_q;
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (load_i) mem_q <= load_mem_i;
    else if (do_push) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      rd_q  <= load_rd_i;
      wr_q  <= load_wr_i;
      cnt_q <= load_cnt_i;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign mem_o  = mem_q;
  assign rd_o   = rd_q;
  assign wr_o   = wr_q;
  assign cnt_o  = cnt_q;
  assign head_o = mem_q[rd_q];

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_full_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !pop_i && !load_i |=> full_o && $stable(wr_q));
endmodule

// File: rtl/cwb_drain.sv
`timescale 1ns/1ps
module cwb_drain
  import cwb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       decouple_i,
  input  logic       freeze_i,
  input  logic       l2_ready_i,
  input  logic       avail_a_i,
  input  logic       avail_b_i,
  input  cwb_entry_t head_a_i,
  input  cwb_entry_t head_b_i,
  output logic       pop_a_o,
  output logic       pop_b_o,
  output logic       l2_valid_o,
  output cwb_entry_t l2_entry_o,
  output logic       l2_src_o
);
  logic valid_q, src_q, last_q;
  cwb_entry_t ent_q;
  logic slot_free, pick_b, have_work, go;

  assign slot_free = !valid_q || l2_ready_i;
  // decoupled: alternate when both wait; last_q = 1 means B went last
  assign pick_b    = decouple_i && avail_b_i && (!avail_a_i || !last_q);
  assign have_work = decouple_i ? (avail_a_i || avail_b_i) : (avail_a_i && avail_b_i);
  assign go        = !freeze_i && slot_free && have_work;
  assign pop_a_o   = go && !pick_b;
  assign pop_b_o   = go && (pick_b || !decouple_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      src_q   <= 1'b0;
      last_q  <= 1'b1;
      ent_q   <= '0;
    end else if (go) begin
      valid_q <= 1'b1;
      ent_q   <= pick_b ? head_b_i : head_a_i;
      src_q   <= pick_b;
      if (decouple_i) last_q <= pick_b;
    end else if (l2_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign l2_valid_o = valid_q;
  assign l2_entry_o = ent_q;
  assign l2_src_o   = src_q;

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_valid_o && !l2_ready_i |=> l2_valid_o && $stable(l2_entry_o) && $stable(l2_src_o));
  assert_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i && !l2_valid_o |=> !l2_valid_o);
  assert_one_pop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decouple_i |-> $countones({pop_a_o, pop_b_o}) <= 1);
endmodule

// File: rtl/dual_store_buffer.sv
`timescale 1ns/1ps
module dual_store_buffer
  import cwb_pkg::*;
#(
  parameter int unsigned DEPTH = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              decouple_i,
  input  logic              recover_i,
  input  logic              faulty_core_i,
  input  logic              a_valid_i,
  input  logic [TAG_W-1:0]  a_tag_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic [MASK_W-1:0] a_mask_i,
  output logic              a_stall_o,
  input  logic              b_valid_i,
  input  logic [TAG_W-1:0]  b_tag_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_data_i,
  input  logic [MASK_W-1:0] b_mask_i,
  output logic              b_stall_o,
  output logic              l2_valid_o,
  input  logic              l2_ready_i,
  output logic [TAG_W-1:0]  l2_tag_o,
  output logic [ADDR_W-1:0] l2_addr_o,
  output logic [DATA_W-1:0] l2_data_o,
  output logic [MASK_W-1:0] l2_mask_o,
  output logic              l2_src_o,
  output logic              recover_done_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned NC = 2;

  logic                   in_valid [NC];
  cwb_entry_t             in_ent   [NC];
  logic                   push     [NC];
  logic                   pop      [NC];
  logic                   load     [NC];
  cwb_entry_t [DEPTH-1:0] mem_w    [NC];
  logic [PW-1:0]          rd_w     [NC];
  logic [PW-1:0]          wr_w     [NC];
  logic [CW-1:0]          cnt_w    [NC];
  cwb_entry_t             head_w   [NC];
  logic                   full_w   [NC];

  logic copied_q, copy_go;
  cwb_entry_t out_ent;

  assign in_valid[0] = a_valid_i;
  assign in_valid[1] = b_valid_i;
  assign in_ent[0]   = '{tag: a_tag_i, addr: a_addr_i, data: a_data_i, mask: a_mask_i};
  assign in_ent[1]   = '{tag: b_tag_i, addr: b_addr_i, data: b_data_i, mask: b_mask_i};

  assign copy_go = recover_i && !l2_valid_o && !copied_q;

  for (genvar c = 0; c < NC; c++) begin : g_core
    assign push[c] = in_valid[c] && !recover_i;
    assign load[c] = copy_go && (faulty_core_i == c[0]);

    cwb_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (push[c]),
      .push_data_i (in_ent[c]),
      .pop_i       (pop[c]),
      .load_i      (load[c]),
      .load_mem_i  (mem_w[NC-1-c]),
      .load_rd_i   (rd_w[NC-1-c]),
      .load_wr_i   (wr_w[NC-1-c]),
      .load_cnt_i  (cnt_w[NC-1-c]),
      .mem_o       (mem_w[c]),
      .rd_o        (rd_w[c]),
      .wr_o        (wr_w[c]),
      .cnt_o       (cnt_w[c]),
      .head_o      (head_w[c]),
      .full_o      (full_w[c])
    );
  end

  cwb_drain u_drain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .decouple_i (decouple_i),
    .freeze_i   (recover_i),
    .l2_ready_i (l2_ready_i),
    .avail_a_i  (cnt_w[0] != '0),
    .avail_b_i  (cnt_w[1] != '0),
    .head_a_i   (head_w[0]),
    .head_b_i   (head_w[1]),
    .pop_a_o    (pop[0]),
    .pop_b_o    (pop[1]),
    .l2_valid_o (l2_valid_o),
    .l2_entry_o (out_ent),
    .l2_src_o   (l2_src_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        copied_q <= 1'b0;
    else if (!recover_i) copied_q <= 1'b0;
    else if (copy_go)   copied_q <= 1'b1;
  end

  assign a_stall_o      = full_w[0];
  assign b_stall_o      = full_w[1];
  assign l2_tag_o       = out_ent.tag;
  assign l2_addr_o      = out_ent.addr;
  assign l2_data_o      = out_ent.data;
  assign l2_mask_o      = out_ent.mask;
  assign recover_done_o = copied_q;

  assert_paired_pop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decouple_i |-> pop[0] == pop[1]);
  assert_paired_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decouple_i && $rose(l2_valid_o) |-> !l2_src_o);
  assert_frozen_counts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_i && !copy_go |=> $stable(cnt_w[0]) && $stable(cnt_w[1]));
  assert_copy_after_flight_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_done_o |-> !l2_valid_o);
  assert_copy_equal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_go |=> cnt_w[0] == cnt_w[1]);
endmodule

// File: tb/dual_store_buffer_test.sv
`timescale 1ns/1ps
module dual_store_buffer_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, decouple, recover, faulty;
  logic a_valid, b_valid, l2_ready;
  logic [31:0] a_tag, a_addr, a_data, b_tag, b_addr, b_data;
  logic [3:0] a_mask, b_mask;
  logic a_stall, b_stall, l2_valid, l2_src, rec_done;
  logic [31:0] l2_tag, l2_addr, l2_data;
  logic [3:0] l2_mask;

  int n_chk = 0, n_bad = 0;
  int log_n = 0;
  logic [31:0] log_tag [64];
  logic [31:0] log_data [64];
  logic [3:0]  log_mask [64];
  logic        log_src [64];

  dual_store_buffer uut (
    .clk_i(clk), .rst_ni(rst_n), .decouple_i(decouple), .recover_i(recover),
    .faulty_core_i(faulty),
    .a_valid_i(a_valid), .a_tag_i(a_tag), .a_addr_i(a_addr), .a_data_i(a_data),
    .a_mask_i(a_mask), .a_stall_o(a_stall),
    .b_valid_i(b_valid), .b_tag_i(b_tag), .b_addr_i(b_addr), .b_data_i(b_data),
    .b_mask_i(b_mask), .b_stall_o(b_stall),
    .l2_valid_o(l2_valid), .l2_ready_i(l2_ready), .l2_tag_o(l2_tag),
    .l2_addr_o(l2_addr), .l2_data_o(l2_data), .l2_mask_o(l2_mask),
    .l2_src_o(l2_src), .recover_done_o(rec_done)
  );

  // accepted writes, seen mid-cycle
  always @(negedge clk) begin
    if (rst_n && l2_valid && l2_ready && log_n < 64) begin
      log_tag[log_n]  = l2_tag;
      log_data[log_n] = l2_data;
      log_mask[log_n] = l2_mask;
      log_src[log_n]  = l2_src;
      log_n++;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic dec);
    rst_n = 1'b0; decouple = dec; recover = 1'b0; faulty = 1'b0;
    a_valid = 1'b0; b_valid = 1'b0; l2_ready = 1'b1;
    a_tag = '0; a_addr = '0; a_data = '0; a_mask = '0;
    b_tag = '0; b_addr = '0; b_data = '0; b_mask = '0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    log_n = 0;
    idle(1);
  endtask

  // one-cycle push; A data = tag^5A5A..., B data = tag^0F0F... so copies are told apart
  task automatic push(input logic da, input logic [31:0] ta, input logic db,
                      input logic [31:0] tb, input logic [31:0] adr);
    a_valid = da; a_tag = ta; a_addr = adr; a_data = ta ^ 32'h5a5a_5a5a; a_mask = 4'hf;
    b_valid = db; b_tag = tb; b_addr = adr; b_data = tb ^ 32'h0f0f_0f0f; b_mask = 4'h3;
    @(posedge clk);
    #1 a_valid = 1'b0; b_valid = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    chk("R1", "l2_valid", l2_valid, 0);
    chk("R1", "a_stall", a_stall, 0);
    chk("R1", "b_stall", b_stall, 0);
    chk("R1", "recover_done", rec_done, 0);
  endtask

  task automatic t_paired;
    do_reset(1'b0);
    push(1, 32'h20, 0, 0, 32'h100);
    push(1, 32'h21, 0, 0, 32'h104);
    push(1, 32'h22, 0, 0, 32'h108);
    idle(3);
    chk("R3", "no write before partner", l2_valid, 0);
    chk("R3", "log count A only", log_n, 0);
    push(0, 0, 1, 32'h90, 32'h100);
    idle(3);
    chk("R3", "one copy", log_n, 1);
    chk("R3", "tag from A", log_tag[0], 32'h20);
    chk("R3", "data from A", log_data[0], 32'h20 ^ 32'h5a5a_5a5a);
    chk("R3", "mask from A", log_mask[0], 4'hf);
    chk("R9", "src paired", log_src[0], 0);
    push(0, 0, 1, 32'h91, 32'h104);
    push(0, 0, 1, 32'h92, 32'h108);
    idle(4);
    chk("R3", "count after catch-up", log_n, 3);
    chk("R3", "order 2nd", log_tag[1], 32'h21);
    chk("R3", "order 3rd", log_tag[2], 32'h22);
  endtask

  task automatic t_no_merge;
    do_reset(1'b0);
    push(1, 32'h10, 1, 32'h10, 32'h200);
    push(1, 32'h11, 1, 32'h11, 32'h200);
    idle(4);
    chk("R2", "same-address writes", log_n, 2);
    chk("R2", "first", log_tag[0], 32'h10);
    chk("R2", "second", log_tag[1], 32'h11);
  endtask

  task automatic t_full;
    do_reset(1'b0);
    for (int i = 0; i < 10; i++) push(1, 32'h100 + i, 0, 0, 32'h300 + 4 * i);
    chk("R4", "a_stall at depth", a_stall, 1);
    chk("R4", "b_stall idle", b_stall, 0);
    chk("R4", "nothing sent", log_n, 0);
    push(1, 32'h1ff, 0, 0, 32'h3f0);
    for (int i = 0; i < 10; i++) push(0, 0, 1, 32'h200 + i, 32'h300 + 4 * i);
    idle(5);
    chk("R4", "drained count", log_n, 10);
    chk("R4", "last tag", log_tag[9], 32'h109);
    chk("R4", "stall cleared", a_stall, 0);
    push(0, 0, 1, 32'h2ff, 32'h3f0);
    idle(4);
    chk("R4", "dropped push absent", log_n, 10);
  endtask

  task automatic t_decoupled;
    do_reset(1'b1);
    l2_ready = 1'b0;
    push(1, 32'h1, 1, 32'h2, 32'h400);
    push(1, 32'h3, 1, 32'h4, 32'h404);
    idle(2);
    chk("R5", "held valid", l2_valid, 1);
    chk("R5", "held tag", l2_tag, 32'h1);
    idle(1);
    chk("R5", "tag stable", l2_tag, 32'h1);
    chk("R5", "src stable", l2_src, 0);
    l2_ready = 1'b1;
    idle(6);
    chk("R8", "count", log_n, 4);
    chk("R8", "order0", log_tag[0], 32'h1);
    chk("R8", "order1", log_tag[1], 32'h2);
    chk("R8", "order2", log_tag[2], 32'h3);
    chk("R8", "order3", log_tag[3], 32'h4);
    chk("R8", "src alt", {log_src[0], log_src[1], log_src[2], log_src[3]}, 4'b0101);
    chk("R8", "B data own", log_data[1], 32'h2 ^ 32'h0f0f_0f0f);
    push(0, 0, 1, 32'h5, 32'h408);
    idle(3);
    chk("R8", "B alone drains", log_n, 5);
    chk("R8", "B alone tag", log_tag[4], 32'h5);
    chk("R8", "B alone src", log_src[4], 1);
  endtask

  task automatic t_recovery;
    do_reset(1'b0);
    l2_ready = 1'b0;
    push(1, 32'h30, 1, 32'h40, 32'h500);
    push(1, 32'h31, 1, 32'h41, 32'h504);
    push(1, 32'h32, 0, 0, 32'h508);
    idle(2);
    chk("R5", "first held", l2_tag, 32'h30);
    recover = 1'b1; faulty = 1'b0;
    idle(2);
    chk("R7", "no copy while in flight", rec_done, 0);
    chk("R6", "in-flight still offered", l2_valid, 1);
    l2_ready = 1'b1;
    idle(1);
    chk("R6", "in-flight completed", log_n, 1);
    push(1, 32'h3f, 1, 32'h4f, 32'h50c);
    idle(3);
    chk("R6", "no new write frozen", l2_valid, 0);
    chk("R6", "log frozen", log_n, 1);
    chk("R7", "done high", rec_done, 1);
    recover = 1'b0;
    idle(1);
    chk("R7", "done falls", rec_done, 0);
    idle(3);
    chk("R7", "copied entry sent", log_n, 2);
    chk("R7", "copied tag", log_tag[1], 32'h41);
    push(0, 0, 1, 32'h42, 32'h510);
    idle(3);
    chk("R7", "A holds no stale entry", log_n, 2);
  endtask

  initial begin
    t_reset();
    t_paired();
    t_no_merge();
    t_full();
    t_decoupled();
    t_recovery();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule